// File: doc/BRIEF.md
# Slow-Peripheral Bus Access Synchronizer

This block connects a fast 16-bit bus master to two slow byte-wide devices. One device is a 16-entry register file and the other is a serial controller. Both devices run from a much slower clock that has no fixed phase relation to the master clock. The slow clock exists only as a phase accumulator in the master domain.

When the master raises a request, the block drops `ready` and waits for the next slow-clock boundary. It then runs the device access for half a slow period and hands the bus back one master cycle after that half-point. The stall therefore follows the slow device's timing instead of a fixed wait-state count.

The block takes the register index from the address and drives the byte lanes. Reads return the device byte on both halves of the data bus. Register-file writes strobe each enabled lane in turn, lower lane first. A debug read skips the stall completely.

Top module: `slowbus_sync`

## Requirements
- R1: An `ACC_W`-bit accumulator is 0 in the first cycle after reset and adds `RATIO` modulo 2^ACC_W every master cycle. A boundary cycle is one where `acc + RATIO` overflows. A half-point cycle is one where bit ACC_W-1 of `acc + RATIO` becomes 1 while bit ACC_W-1 of `acc` is 0, with no overflow.
- R2: During reset `ready` is 1, `p_sel`, `s_sel` and `bus_we` are 0, and `rdata` is 0.
- R3: A request accepted in cycle r (`req`=1 while `ready`=1, and not a debug read) holds `ready` low from cycle r+1 to cycle h+1. Here w is the first boundary cycle after r and h is the first half-point cycle after w. The access starts in cycle w+1.
- R4: Each stall length S (cycles with `ready` low) satisfies S·RATIO ≥ 2^(ACC_W-1) and S·RATIO ≤ 3·2^(ACC_W-1) + 3·RATIO.
- R5: `req` is ignored while `ready` is low. It causes no strobe and no change of the access in progress.
- R6: The device index `bus_idx` is address bits [IDX_LSB+IDX_W-1:IDX_LSB] (11:8 by default) and is captured at acceptance.
- R7: A register-file read strobes `p_sel` with `bus_we`=0 in cycle w+1. From cycle w+2, `rdata` holds `{p_rdata, p_rdata}` as sampled in that cycle.
- R8: A register-file write uses `be[0]` for lane [7:0] and `be[1]` for lane [15:8]. With both lanes enabled, the low byte is written in cycle w+1 and the high byte in w+2. With one lane enabled, that lane's byte is written in w+1. With no lane enabled, nothing is strobed.
- R9: A debug read (`debug`=1, `we`=0, `ready`=1) strobes the selected device in the same cycle, with its index taken from the live address. `rdata` is updated at the next edge and `ready` stays 1.
- R10: `debug` has no effect on writes. They stall exactly as in R3.
- R11: With `dev`=1 the serial controller is used (`s_sel` in place of `p_sel`), with one strobe in w+1. A serial write sends `wdata[15:8]` when `hi_src`=1 and `wdata[7:0]` otherwise. A serial read returns `{s_rdata, s_rdata}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| debug | input | 1 | Side-effect-free read, no stall |
| dev | input | 1 | 0 = register file, 1 = serial controller |
| hi_src | input | 1 | Serial write takes its data from the upper byte |
| addr | input | ADDR_W | Master address |
| be | input | 2 | Byte-lane enables |
| wdata | input | 16 | Write data |
| ready | output | 1 | Master may proceed / start a request |
| rdata | output | 16 | Read data, byte duplicated |
| p_sel | output | 1 | Register-file strobe |
| s_sel | output | 1 | Serial-controller strobe |
| bus_we | output | 1 | Strobe is a write |
| bus_idx | output | IDX_W | Device register index |
| bus_wdata | output | 8 | Device write byte |
| p_rdata | input | 8 | Register-file read byte |
| s_rdata | input | 8 | Serial-controller read byte |

## Verification
The bench keeps the default parameters: ACC_W=16 and RATIO=3423, the ratio of a 783.36 kHz slow clock to a 15 MHz master. That gives a slow period of about 19.1 master cycles and a half-point about 9.6 cycles after each boundary. Before each request the bench waits for one of 19 accumulator phase bins, and it pairs every bin with every operation kind. Requests therefore land at each master-cycle phase of the slow period, which exercises both the shortest and the longest stalls in R4.

// File: rtl/slowbus_sync.sv
module slowbus_sync #(
  parameter int ACC_W   = 16,
  parameter int RATIO   = 3423,
  parameter int ADDR_W  = 12,
  parameter int IDX_LSB = 8,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              debug,
  input  logic              dev,
  input  logic              hi_src,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        be,
  input  logic [15:0]       wdata,
  output logic              ready,
  output logic [15:0]       rdata,
  output logic              p_sel,
  output logic              s_sel,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_idx,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        p_rdata,
  input  logic [7:0]        s_rdata
);
  localparam logic [ACC_W:0] INC = (ACC_W+1)'(RATIO);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACC, S_DONE} st_t;

  st_t              st;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             tick, half;
  logic [1:0]       step;
  logic             r_we, r_dev, r_hi;
  logic [1:0]       r_be;
  logic [IDX_W-1:0] r_idx;
  logic [15:0]      r_wdata;
  logic             dbg, start, st0, st1, lo_wr, hi_wr, rd_cap;
  logic [7:0]       d_live, d_reg;
  logic             unused_addr;

  assign unused_addr = ^{addr[IDX_LSB-1:0], addr[ADDR_W-1:IDX_LSB+IDX_W]};

  assign sum  = {1'b0, acc} + INC;
  assign tick = sum[ACC_W];
  assign half = ~acc[ACC_W-1] & sum[ACC_W-1] & ~sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= sum[ACC_W-1:0];

  assign dbg   = (st == S_IDLE) & req & debug & ~we;
  assign start = (st == S_IDLE) & req & ~dbg;
  assign ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      r_we    <= 1'b0;
      r_dev   <= 1'b0;
      r_hi    <= 1'b0;
      r_be    <= '0;
      r_idx   <= '0;
      r_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_WAIT;
          r_we    <= we;
          r_dev   <= dev;
          r_hi    <= hi_src;
          r_be    <= be;
          r_idx   <= addr[IDX_LSB +: IDX_W];
          r_wdata <= wdata;
        end
        S_WAIT: if (tick) begin
          st   <= S_ACC;
          step <= '0;
        end
        S_ACC: begin
          if (step != 2'd2) step <= step + 2'd1;
          if (half) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign st0    = (st == S_ACC) & (step == 2'd0);
  assign st1    = (st == S_ACC) & (step == 2'd1);
  assign lo_wr  = st0 & ~r_dev & r_we & r_be[0];
  assign hi_wr  = ~r_dev & r_we & r_be[1] & (r_be[0] ? st1 : st0);
  assign rd_cap = st0 & ~r_we;

  assign p_sel     = (dbg & ~dev) | (rd_cap & ~r_dev) | lo_wr | hi_wr;
  assign s_sel     = (dbg & dev) | (st0 & r_dev);
  assign bus_we    = (st == S_ACC) & r_we & (p_sel | s_sel);
  assign bus_idx   = dbg ? addr[IDX_LSB +: IDX_W] : r_idx;
  assign bus_wdata = (hi_wr | (r_dev & r_hi)) ? r_wdata[15:8] : r_wdata[7:0];

  assign d_live = dev   ? s_rdata : p_rdata;
  assign d_reg  = r_dev ? s_rdata : p_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      rdata <= '0;
    else if (dbg)    rdata <= {d_live, d_live};
    else if (rd_cap) rdata <= {d_reg, d_reg};
endmodule

// File: rtl/slowbus_sync_chk.sv
module slowbus_sync_chk #(
  parameter int ACC_W = 16,
  parameter int RATIO = 3423
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic we,
  input logic debug,
  input logic ready,
  input logic p_sel,
  input logic s_sel,
  input logic bus_we
);
  localparam longint HALF_SPAN = longint'(1) << (ACC_W - 1);
  localparam longint LO_LIM    = HALF_SPAN;
  localparam longint HI_LIM    = 3 * HALF_SPAN + 3 * longint'(RATIO);

  int unsigned cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= 0;
    else if (!ready) cnt <= cnt + 1;
    else             cnt <= 0;

  assert_stall_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (longint'(cnt) * RATIO >= LO_LIM && longint'(cnt) * RATIO <= HI_LIM));

  assert_drop_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(req && !(debug && !we)));

  assert_strobe_context_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_sel || s_sel) && ready) |-> (req && debug && !we && !bus_we));

  assert_dbg_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && debug && !we) |=> ready);

  assert_write_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && we) |=> !ready);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_sel && s_sel));
endmodule

bind slowbus_sync slowbus_sync_chk #(.ACC_W(ACC_W), .RATIO(RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .debug(debug),
  .ready(ready), .p_sel(p_sel), .s_sel(s_sel), .bus_we(bus_we)
);

// File: tb/test_slowbus_sync.sv
module test_slowbus_sync;
  localparam int ACC_W = 16;
  localparam int RATIO = 3423;
  localparam longint M = longint'(1) << ACC_W;
  localparam longint R = RATIO;

  logic clk = 1'b0;
  logic rst_n;
  logic req, we, debug, dev, hi_src;
  logic [11:0] addr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic        ready, p_sel, s_sel, bus_we;
  logic [15:0] rdata;
  logic [3:0]  bus_idx;
  logic [7:0]  bus_wdata, p_rdata, s_rdata;

  always #2 clk = ~clk;

  function automatic logic [7:0] fval(logic d, logic [3:0] i);
    return d ? (8'hC3 ^ {i, i}) : (8'h5A + {4'h0, i} * 8'd7);
  endfunction

  assign p_rdata = fval(1'b0, bus_idx);
  assign s_rdata = fval(1'b1, bus_idx);

  slowbus_sync #(.ACC_W(ACC_W), .RATIO(RATIO)) i_slowbus_sync (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .debug(debug), .dev(dev),
    .hi_src(hi_src), .addr(addr), .be(be), .wdata(wdata), .ready(ready),
    .rdata(rdata), .p_sel(p_sel), .s_sel(s_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .p_rdata(p_rdata), .s_rdata(s_rdata)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  longint k, macc, mr, mw, mh;
  bit busy;
  bit m_we, m_dev, m_hi, m_dbg;
  logic [1:0]  m_be;
  logic [3:0]  m_idx;
  logic [15:0] m_wdata, exp_rd;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, k, act, expv);
    end
  endtask

  task automatic compare();
    bit rdy_e, dbg_e, pe, se, we_e;
    logic [3:0] idx_e;
    logic [7:0] wd_e;
    string tag;
    rdy_e = !busy;
    dbg_e = rdy_e && req && debug && !we;
    pe = 0; se = 0; we_e = 0; idx_e = m_idx; wd_e = 8'h00;
    tag = busy ? (m_dev ? "R11" : (m_we ? "R8" : "R7")) : "R5";
    if (busy && m_we && m_dbg) tag = "R10";
    if (dbg_e) begin
      pe = !dev; se = dev; idx_e = addr[11:8]; tag = "R9";
    end else if (busy && k == mw + 1) begin
      if (m_dev) begin
        se = 1; we_e = m_we; wd_e = m_hi ? m_wdata[15:8] : m_wdata[7:0];
      end else if (!m_we) pe = 1;
      else if (m_be[0]) begin pe = 1; we_e = 1; wd_e = m_wdata[7:0]; end
      else if (m_be[1]) begin pe = 1; we_e = 1; wd_e = m_wdata[15:8]; end
    end else if (busy && k == mw + 2 && !m_dev && m_we && m_be == 2'b11) begin
      pe = 1; we_e = 1; wd_e = m_wdata[15:8];
    end
    if (busy && req && !pe && !se) tag = "R5";
    check(ready == rdy_e, busy && m_dbg && m_we ? "R10" : "R1,R3", "ready", ready, rdy_e);
    check(p_sel == pe, tag, "p_sel", p_sel, pe);
    check(s_sel == se, tag, "s_sel", s_sel, se);
    if (pe || se) begin
      check(bus_we == we_e, tag, "bus_we", bus_we, we_e);
      check(bus_idx == idx_e, "R6", "bus_idx", bus_idx, idx_e);
      if (we_e) check(bus_wdata == wd_e, tag, "bus_wdata", bus_wdata, wd_e);
    end
    check(rdata == exp_rd, m_dev ? "R11" : "R7", "rdata", rdata, exp_rd);
  endtask

  task automatic model_edge();
    bit rdy_e, dbg_e;
    longint a, kk, s;
    logic [7:0] b;
    rdy_e = !busy;
    dbg_e = rdy_e && req && debug && !we;
    if (dbg_e) begin
      b = fval(dev, addr[11:8]); exp_rd = {b, b};
    end
    if (busy && k == mw + 1 && !m_we) begin
      b = fval(m_dev, m_idx); exp_rd = {b, b};
    end
    if (busy && k == mh + 1) begin
      busy = 0;
      s = mh + 1 - mr;
      check(s * R >= M / 2 && s * R <= 3 * (M / 2) + 3 * R, "R4", "stall length", s, M / (2 * R));
    end
    if (rdy_e && req && !dbg_e) begin
      mr = k; m_we = we; m_dev = dev; m_hi = hi_src; m_be = be; m_dbg = debug;
      m_idx = addr[11:8]; m_wdata = wdata;
      a = macc; kk = k;
      do begin a = (a + R) % M; kk++; end while (a + R < M);
      mw = kk;
      a = (a + R) % M; kk++;
      while (!(a < M / 2 && a + R >= M / 2 && a + R < M)) begin a = (a + R) % M; kk++; end
      mh = kk;
      busy = 1;
    end
    macc = (macc + R) % M;
    k++;
  endtask

  task automatic run_cycle();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R3 watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    req = 0; we = 0; debug = 0; dev = 0; hi_src = 0; addr = '0; be = '0; wdata = '0;
    k = 0; macc = 0; busy = 0; exp_rd = '0; mr = 0; mw = 0; mh = 0;
    m_we = 0; m_dev = 0; m_hi = 0; m_dbg = 0; m_be = '0; m_idx = '0; m_wdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ready == 1'b1, "R2", "reset ready", ready, 1);
    check(p_sel == 1'b0 && s_sel == 1'b0, "R2", "reset strobes", {p_sel, s_sel}, 0);
    check(bus_we == 1'b0, "R2", "reset bus_we", bus_we, 0);
    check(rdata == 16'h0, "R2", "reset rdata", rdata, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 190; i++) begin
      int op, target;
      op = i % 10;
      target = i % 19;
      req = 0;
      while (busy || int'((macc * 19) / M) != target) run_cycle();
      addr = 12'(i * 37 + 5); wdata = 16'(i * 613 + 16'h1234);
      dev = 0; hi_src = 0; debug = 0; we = 0; be = 2'b11;
      case (op)
        1: we = 1;
        2: begin we = 1; be = 2'b01; end
        3: begin we = 1; be = 2'b10; end
        4: begin we = 1; be = 2'b00; end
        5: begin we = 1; dev = 1; hi_src = 1; end
        6: begin we = 1; dev = 1; hi_src = 0; end
        7: dev = 1;
        8: begin debug = 1; dev = (i / 10) % 2 == 1; end
        9: begin debug = 1; we = 1; end
        default: ;
      endcase
      req = 1;
      run_cycle();
      while (busy) begin
        if (i % 3 == 0) begin
          req = 1; we = ~we; addr = addr + 12'h1A3; debug = ~debug;
        end else req = 0;
        run_cycle();
      end
    end
    req = 0;
    repeat (4) run_cycle();
    finish_run();
  end
endmodule